// File: doc/BRIEF.md
# Timestamp Counter with Compare Output

A free-running 64-bit timestamp counter that adds a programmable step on every reference clock. A compare unit watches the counter and, when the counter is exactly equal to a programmed 64-bit compare value, drives a pulse on a single output line. It also pushes an event record holding the event type and the matching timestamp into an 8-entry event FIFO that a host drains through a simple pop interface.

Software configures the block through a small word-addressed register port. That port sets the step, the compare value, the compare enable, the output polarity and the pulse length, and it loads the counter atomically through a low/high register pair. Because equality is exact, a step above one can carry the counter past the compare value. In that case neither a pulse nor an event is produced. Software that needs a guaranteed hit must choose a compare value reachable from the loaded value in whole steps.

Top module: `ts_cmp_top`

## Requirements
- R1: On reset the counter is 0, the step is 1, compare is disabled, the pulse length is 1, polarity is normal, cmp_o is 1 and the event FIFO is empty. CTRL reads 32'h100 and STEP reads 1.
- R2: Register map (word address on reg_addr_i): 0 CTRL, 1 STEP, 2 CMP_LO, 3 CMP_HI, 4 CNT_LO, 5 CNT_HI, 6 STATUS. Every clock the counter adds STEP. A write of 0 to STEP stores 1.
- R3: A write to CNT_LO only stages the low half. A write to CNT_HI loads {written value, staged low half} into the counter on that same clock edge, and the load has priority over the increment. Reads of addresses 4 and 5 return the live counter halves.
- R4: A match requires the counter to be exactly equal to {CMP_HI, CMP_LO}. A counter that steps past the compare value gives no pulse and no event.
- R5: CTRL bit 1 clear: cmp_o idles at 1 and pulses to 0. CTRL bit 1 set: cmp_o idles at 0 and pulses to 1.
- R6: The pulse starts in the clock after the match cycle and lasts the number of clocks given by CTRL[15:8]. A written value of 0 is stored as 1.
- R7: While CTRL bit 0 (compare enable) is clear, no match occurs and cmp_o stays at its idle level.
- R8: Each match pushes an event of type 4'h1 and the matching counter value into an 8-entry FIFO. A match that arrives while the FIFO is full is dropped, and the older entries are kept.
- R9: evt_valid_o is high while the FIFO is not empty, and evt_type_o/evt_ts_o show the oldest entry. evt_rd_i pops one entry. STATUS bit 0 is not-empty, bit 1 is full, and bits [15:8] hold the entry count. A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cnt_o | output | 64 | Live counter value |
| cmp_o | output | 1 | Compare pulse output |
| evt_rd_i | input | 1 | Pop the oldest event |
| evt_valid_o | output | 1 | Event FIFO not empty |
| evt_type_o | output | 4 | Type of the oldest event |
| evt_ts_o | output | 64 | Timestamp of the oldest event |

## Verification
A compare match pushes into the event FIFO on the same clock edge that a host pop can remove the head entry, so push and pop can coincide. The bench leaves one event in the FIFO and loads the counter one step below a new compare value. It then raises evt_rd_i in exactly the cycle where the counter equals that value. The result is judged at the ports: the count in STATUS must still be one, and the head must now carry the new timestamp.

// File: rtl/ts_cmp_pkg.sv
package ts_cmp_pkg;
  localparam int TS_W    = 64;
  localparam int EVT_TW  = 4;
  localparam logic [EVT_TW-1:0] EVT_CMP = 4'h1;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STEP   = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5,
    A_STAT   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [EVT_TW-1:0] kind;
    logic [TS_W-1:0]   ts;
  } evt_t;
endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int TS_W   = 64,
  parameter int STEP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_i,
  input  logic [TS_W-1:0]   load_val_i,
  output logic [TS_W-1:0]   cnt_o
);
  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else             cnt_q <= cnt_q + TS_W'(step_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ts_compare.sv
module ts_compare #(
  parameter int TS_W  = 64,
  parameter int PLS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [PLS_W-1:0] len_i,
  input  logic [TS_W-1:0]  cnt_i,
  input  logic [TS_W-1:0]  cmp_val_i,
  output logic             match_o,
  output logic [PLS_W-1:0] remain_o,
  output logic             cmp_o
);
  logic [PLS_W-1:0] remain_q;
  logic             active;

  assign match_o = en_i && (cnt_i == cmp_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              remain_q <= '0;
    else if (match_o)         remain_q <= len_i;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign active   = (remain_q != '0);
  assign remain_o = remain_q;
  // idle high, low pulse unless inverted
  assign cmp_o    = inv_i ? active : ~active;
endmodule

// File: rtl/ts_evt_fifo.sv
module ts_evt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 68,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;   // new entry dropped when full
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (do_push && wr_q == AW'(g))     mem_q[g] <= data_i;
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ts_cmp_top.sv
module ts_cmp_top
  import ts_cmp_pkg::*;
#(
  parameter int STEP_W    = 32,
  parameter int PLS_W     = 8,
  parameter int EVT_DEPTH = 8,
  localparam int CW       = $clog2(EVT_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [63:0]       cnt_o,
  output logic              cmp_o,
  input  logic              evt_rd_i,
  output logic              evt_valid_o,
  output logic [3:0]        evt_type_o,
  output logic [63:0]       evt_ts_o
);
  logic              cmp_en_q, inv_q;
  logic [PLS_W-1:0]  len_q;
  logic [STEP_W-1:0] step_q;
  logic [TS_W-1:0]   cmp_val_q;
  logic [31:0]       lo_stage_q;
  logic [TS_W-1:0]   cnt;
  logic              load_fire;
  logic [TS_W-1:0]   load_val;
  logic              match;
  logic [PLS_W-1:0]  remain;
  logic [CW-1:0]     fcount;
  logic              fempty, ffull, pop_fire;
  evt_t              push_evt, head_evt;

  logic              wr_ctrl, wr_step;
  logic [PLS_W-1:0]  len_wr;
  logic [STEP_W-1:0] step_wr;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_step   = reg_we_i && (reg_addr_i == A_STEP);
  assign load_fire = reg_we_i && (reg_addr_i == A_CNT_HI);
  assign load_val  = {reg_wdata_i, lo_stage_q};
  assign len_wr    = reg_wdata_i[8 +: PLS_W];
  assign step_wr   = reg_wdata_i[STEP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_en_q   <= 1'b0;
      inv_q      <= 1'b0;
      len_q      <= PLS_W'(1);
      step_q     <= STEP_W'(1);
      cmp_val_q  <= '0;
      lo_stage_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL: begin
          cmp_en_q <= reg_wdata_i[0];
          inv_q    <= reg_wdata_i[1];
          len_q    <= (len_wr == '0) ? PLS_W'(1) : len_wr;
        end
        A_STEP:   step_q <= (step_wr == '0) ? STEP_W'(1) : step_wr;
        A_CMP_LO: cmp_val_q[31:0]  <= reg_wdata_i;
        A_CMP_HI: cmp_val_q[63:32] <= reg_wdata_i;
        A_CNT_LO: lo_stage_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[0]          = cmp_en_q;
        reg_rdata_o[1]          = inv_q;
        reg_rdata_o[8 +: PLS_W] = len_q;
      end
      A_STEP:   reg_rdata_o = 32'(step_q);
      A_CMP_LO: reg_rdata_o = cmp_val_q[31:0];
      A_CMP_HI: reg_rdata_o = cmp_val_q[63:32];
      A_CNT_LO: reg_rdata_o = cnt[31:0];
      A_CNT_HI: reg_rdata_o = cnt[63:32];
      A_STAT: begin
        reg_rdata_o[0]       = !fempty;
        reg_rdata_o[1]       = ffull;
        reg_rdata_o[8 +: CW] = fcount;
      end
      default: ;
    endcase
  end

  ts_counter #(.TS_W(TS_W), .STEP_W(STEP_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i     (step_q),
    .load_i     (load_fire),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  ts_compare #(.TS_W(TS_W), .PLS_W(PLS_W)) u_cmp (
    .clk_i, .rst_ni,
    .en_i      (cmp_en_q),
    .inv_i     (inv_q),
    .len_i     (len_q),
    .cnt_i     (cnt),
    .cmp_val_i (cmp_val_q),
    .match_o   (match),
    .remain_o  (remain),
    .cmp_o     (cmp_o)
  );

  assign push_evt = '{kind: EVT_CMP, ts: cnt};
  assign pop_fire = evt_rd_i && !fempty;

  ts_evt_fifo #(.DEPTH(EVT_DEPTH), .W($bits(evt_t))) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (match),
    .data_i  (push_evt),
    .pop_i   (evt_rd_i),
    .data_o  (head_evt),
    .count_o (fcount),
    .empty_o (fempty),
    .full_o  (ffull)
  );

  assign cnt_o       = cnt;
  assign evt_valid_o = !fempty;
  assign evt_type_o  = head_evt.kind;
  assign evt_ts_o    = head_evt.ts;
endmodule

// File: rtl/ts_cmp_chk.sv
module ts_cmp_chk #(
  parameter int STEP_W    = 32,
  parameter int PLS_W     = 8,
  parameter int EVT_DEPTH = 8,
  localparam int CW       = $clog2(EVT_DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [63:0]       cnt,
  input logic [STEP_W-1:0] step_q,
  input logic              load_fire,
  input logic [63:0]       load_val,
  input logic              match,
  input logic              cmp_en_q,
  input logic [PLS_W-1:0]  len_q,
  input logic [PLS_W-1:0]  remain,
  input logic [CW-1:0]     fcount,
  input logic              ffull,
  input logic              pop_fire
);
  assert_step_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_fire |=> cnt == $past(cnt) + 64'($past(step_q)));

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fire |=> cnt == $past(load_val));

  assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> remain == $past(len_q));

  assert_quiet_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_q && remain == '0) |=> remain == '0);

  assert_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !ffull && !pop_fire) |=> fcount == $past(fcount) + 1'b1);

  assert_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcount <= CW'(EVT_DEPTH));

  assert_pushpop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !ffull && pop_fire) |=> $stable(fcount));
endmodule

bind ts_cmp_top ts_cmp_chk #(.STEP_W(STEP_W), .PLS_W(PLS_W), .EVT_DEPTH(EVT_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt       (cnt),
  .step_q    (step_q),
  .load_fire (load_fire),
  .load_val  (load_val),
  .match     (match),
  .cmp_en_q  (cmp_en_q),
  .len_q     (len_q),
  .remain    (remain),
  .fcount    (fcount),
  .ffull     (ffull),
  .pop_fire  (pop_fire)
);

// File: tb/tb_ts_cmp_top.sv
module tb_ts_cmp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] cnt;
  logic        cmp;
  logic        evt_rd = 1'b0;
  logic        evt_valid;
  logic [3:0]  evt_type;
  logic [63:0] evt_ts;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ts_cmp_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cnt_o(cnt), .cmp_o(cmp),
    .evt_rd_i(evt_rd), .evt_valid_o(evt_valid), .evt_type_o(evt_type), .evt_ts_o(evt_ts)
  );

  typedef struct packed {
    int step; int off; int len; int pol; int hit;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1, 3, 1, 0, 1},
    '{1, 5, 3, 1, 1},
    '{4, 8, 2, 0, 1},
    '{4, 6, 1, 0, 0},
    '{3, 9, 4, 1, 1},
    '{2, 7, 1, 1, 0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pop();
    @(negedge clk);
    evt_rd = 1'b1;
    @(posedge clk);
    #1 evt_rd = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    wr(3'd4, v[31:0]);
    wr(3'd5, v[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnt == 64'd0, "R1 cnt", cnt, 0);
    chk(cmp == 1'b1, "R1 cmp_o", {63'd0, cmp}, 1);
    chk(!evt_valid, "R1 fifo", {63'd0, evt_valid}, 0);
    rst_n = 1'b1;
    rd(3'd1, r); chk(r == 32'd1, "R1 step", {32'd0, r}, 1);
    rd(3'd0, r); chk(r == 32'h100, "R1 ctrl", {32'd0, r}, 64'h100);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 6; i++) begin
      logic [63:0] base, cval;
      int nact, first;
      base = 64'h2_0000_0000 + 64'(i) * 64'h1000;
      cval = base + 64'(VEC[i].off);
      wr(3'd0, 32'd0);
      wr(3'd1, 32'(VEC[i].step));
      wr(3'd2, cval[31:0]);
      wr(3'd3, cval[63:32]);
      wr(3'd0, 32'd1 | (32'(VEC[i].pol) << 1) | (32'(VEC[i].len) << 8));
      load(base);
      nact = 0; first = -1;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (k == 0) begin
          chk(cnt == base, "R3 load", cnt, base);
          chk(cmp == (VEC[i].pol == 0), "R5 idle", {63'd0, cmp}, 64'(VEC[i].pol == 0));
        end
        if (k == 1) chk(cnt == base + 64'(VEC[i].step), "R2 step", cnt, base + 64'(VEC[i].step));
        if ((VEC[i].pol != 0) ? cmp : !cmp) begin
          nact++;
          if (first < 0) first = k;
        end
      end
      if (VEC[i].hit != 0) begin
        chk(nact == VEC[i].len, "R6 len", 64'(nact), 64'(VEC[i].len));
        chk(first == VEC[i].off / VEC[i].step + 1, "R5 start", 64'(first), 64'(VEC[i].off / VEC[i].step + 1));
        chk(evt_valid && evt_type == 4'h1, "R8 type", {60'd0, evt_type}, 1);
        chk(evt_ts == cval, "R8 ts", evt_ts, cval);
        pop();
        @(negedge clk);
        chk(!evt_valid, "R9 drain", {63'd0, evt_valid}, 0);
      end else begin
        chk(nact == 0, "R4 skip pulse", 64'(nact), 0);
        chk(!evt_valid, "R4 skip event", {63'd0, evt_valid}, 0);
      end
    end

    // R2 step 0 stored as 1
    wr(3'd1, 32'd0);
    rd(3'd1, r); chk(r == 32'd1, "R2 step zero", {32'd0, r}, 1);
    @(negedge clk); c0 = cnt;
    @(negedge clk); chk(cnt == c0 + 1, "R2 step zero inc", cnt, c0 + 1);

    // R6 len 0 stored as 1
    wr(3'd0, 32'd0);
    rd(3'd0, r); chk(r == 32'h100, "R6 len zero", {32'd0, r}, 64'h100);

    // R7 enable clear: exact hit ignored
    wr(3'd3, 32'd3);
    wr(3'd2, 32'h80);
    load({32'd3, 32'h7f});
    begin
      int nact7;
      nact7 = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!cmp) nact7++;
      end
      chk(nact7 == 0, "R7 no pulse", 64'(nact7), 0);
      chk(!evt_valid, "R7 no event", {63'd0, evt_valid}, 0);
    end

    // R8 overflow: nine matches, eight kept
    wr(3'd0, 32'h101);
    for (int j = 0; j < 9; j++) begin
      logic [31:0] l;
      l = 32'h100 + 32'(j) * 32'h40;
      wr(3'd2, l);
      load({32'd3, l - 32'd1});
      repeat (3) @(negedge clk);
    end
    rd(3'd6, r);
    chk(r[15:8] == 8'd8 && r[1] && r[0], "R8 full status", {32'd0, r}, 64'h803);
    for (int j = 0; j < 8; j++) begin
      logic [63:0] e;
      e = {32'd3, 32'h100 + 32'(j) * 32'h40};
      @(negedge clk);
      chk(evt_ts == e, "R8 order", evt_ts, e);
      pop();
    end
    @(negedge clk);
    chk(!evt_valid, "R8 drop newest", {63'd0, evt_valid}, 0);

    // R9 push and pop in the same cycle
    wr(3'd2, 32'h1000);
    load({32'd3, 32'h0fff});
    repeat (3) @(negedge clk);
    chk(evt_valid, "R9 one entry", {63'd0, evt_valid}, 1);
    wr(3'd2, 32'h2000);
    load({32'd3, 32'h1fff});
    @(negedge clk);
    @(negedge clk);
    chk(cnt == {32'd3, 32'h2000}, "R9 match cycle", cnt, {32'd3, 32'h2000});
    evt_rd = 1'b1;
    @(posedge clk);
    #1 evt_rd = 1'b0;
    rd(3'd6, r);
    chk(r[15:8] == 8'd1 && r[0], "R9 count kept", {32'd0, r}, 64'h101);
    chk(evt_ts == {32'd3, 32'h2000}, "R9 new head", evt_ts, {32'd3, 32'h2000});
    pop();
    rd(3'd6, r);
    chk(r[15:0] == 16'd0, "R9 empty", {32'd0, r}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule